// File: doc/BRIEF.md
# Split-Word Accumulator Arithmetic and Shift Unit

This unit computes one new accumulator value per issued operation on a 24-bit two's-complement word. Besides ordinary full-word arithmetic, logic and shifts, it offers a packed mode. In packed mode the word holds two independent 11-bit signed lanes, with a 2-bit middle field between them. A packed operation works on both lanes at once, or on a single lane. The middle field and any lane not selected keep their previous contents.

A sequencer presents the accumulator (A), the lower accumulator (L) and the number operand (N) with a 4-bit operation code and a shift count, and raises `opGo` for one cycle. On the next clock edge the unit registers the new A, carries L through unchanged and returns a duration in word times that the sequencer uses to pace itself. The result itself is always ready one cycle after issue. The reported duration is only bookkeeping for the sequencer.

Top module: `split_word_alu`

## Requirements
- R1: While `rstN` is low, `aOut`, `lOut` and `wordTimes` read zero and `resValid` is low.
- R2: If `opGo` is high at a rising edge, `aOut`, `lOut` and `wordTimes` take their new values at that edge and `resValid` is high for exactly the following cycle. `lOut` always takes the `lIn` value captured with the operation. If `opGo` is low, all outputs hold and `resValid` is low.
- R3: Code 0 gives A+N and code 1 gives A−N, both modulo 2^24.
- R4: Code 2 gives −A modulo 2^24. Code 3 gives −A when bit 23 of A is 0 and leaves A unchanged when bit 23 is 1. Code 15 passes A through unchanged.
- R5: Code 4 gives the bitwise AND of A and L.
- R6: Code 5 gives A·2^count truncated to 24 bits. Code 6 gives an arithmetic right shift that fills the vacated high bits with bit 23. A count of 24 or more yields 0 for the left shift and 24 copies of bit 23 for the right shift.
- R7: Packed lanes sit at bits 23:13 (high lane) and 10:0 (low lane), with the middle field at bits 12:11. Code 7 adds N to A in each lane modulo 2048, with no carry between the lanes. Code 8 subtracts N from A in each lane modulo 2048. Both codes keep A's middle field.
- R8: Code 9 shifts both lanes left and code 10 shifts both lanes right arithmetically, each lane on its own. A count of 11 or more clears a lane on a left shift and fills it with its sign on a right shift. The middle field is kept.
- R9: The single-lane shifts are: code 11, high lane right; code 12, low lane right; code 13, high lane left; code 14, low lane left. The lane that is not named and the middle field are unchanged.
- R10: The shift codes (5, 6 and 9 to 14) report `wordTimes` = count + 1. All other codes report 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opGo | input | 1 | Issue strobe; operands are captured at the edge where it is high |
| opCode | input | 4 | Operation code (see R3 to R10) |
| shiftCnt | input | 5 | Shift count in bit positions |
| aIn | input | 24 | Accumulator operand |
| lIn | input | 24 | Lower accumulator operand |
| nIn | input | 24 | Number operand |
| aOut | output | 24 | Registered new accumulator |
| lOut | output | 24 | Registered lower accumulator |
| wordTimes | output | 6 | Duration of the operation in word times |
| resValid | output | 1 | One-cycle pulse marking a new result |

## Verification
The bound assertions check several properties on every cycle: the issue-to-result pulse, holding of the outputs while idle, the pass-through of L, preservation of the middle field for every packed code, untouched lanes for single-lane shifts, and the duration rule. Arithmetic values cannot be checked that way. Lane wrap without carry leakage, sign fill at and beyond the saturation counts, and the sign-dependent behaviour of the minus-magnitude operation are shown only by the bench. It sweeps every shift code over every count against several patterns, and compares the arithmetic codes against integer models over boundary values and a pseudo-random sequence.

// File: rtl/split_word_pkg.sv
package split_word_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_NEG  = 4'd2,
    OP_MMAG = 4'd3,
    OP_AND  = 4'd4,
    OP_SHL  = 4'd5,
    OP_SHR  = 4'd6,
    OP_PADD = 4'd7,
    OP_PSUB = 4'd8,
    OP_PSHL = 4'd9,
    OP_PSHR = 4'd10,
    OP_HISR = 4'd11,
    OP_LOSR = 4'd12,
    OP_HISL = 4'd13,
    OP_LOSL = 4'd14,
    OP_PASS = 4'd15
  } aluOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic addSel;
    logic subtract;
    logic split;
    logic shiftSel;
    logic shiftLeft;
    logic laneHiEn;
    logic laneLoEn;
    logic negSel;
    logic minMag;
    logic andSel;
  } ctrlStrobe_t;

endpackage

// File: rtl/split_lane_unit.sv
module split_lane_unit #(
  parameter int LANE_W = 11,
  parameter int CNT_W  = 5
) (
  input  logic [LANE_W-1:0] aLane,
  input  logic [LANE_W-1:0] nLane,
  input  logic              subtract,
  input  logic              shiftLeft,
  input  logic [CNT_W-1:0]  shiftCnt,
  output logic [LANE_W-1:0] sumLane,
  output logic [LANE_W-1:0] shiftLane
);

  localparam logic [CNT_W:0] LANE_LIM = (CNT_W+1)'(LANE_W);

  logic [LANE_W-1:0] nTerm;
  logic              satur;

  assign nTerm   = subtract ? (~nLane + LANE_W'(1)) : nLane;
  assign sumLane = aLane + nTerm;
  assign satur   = ({1'b0, shiftCnt} >= LANE_LIM);

  always_comb begin
    if (shiftLeft) begin
      shiftLane = satur ? '0 : (aLane << shiftCnt);
    end else begin
      shiftLane = satur ? {LANE_W{aLane[LANE_W-1]}}
                        : LANE_W'($signed(aLane) >>> shiftCnt);
    end
  end

endmodule

// File: rtl/split_word_ctrl.sv
module split_word_ctrl
  import split_word_pkg::*;
#(
  parameter int CNT_W = 5,
  localparam int LAT_W = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             opGo,
  input  logic [3:0]       opCode,
  input  logic [CNT_W-1:0] shiftCnt,
  output ctrlStrobe_t      strobe,
  output logic [LAT_W-1:0] wordTimes,
  output logic             resValid
);

  always_comb begin
    strobe      = '0;
    strobe.load = opGo;
    case (aluOp_e'(opCode))
      OP_ADD:  strobe.addSel = 1'b1;
      OP_SUB:  begin strobe.addSel = 1'b1; strobe.subtract = 1'b1; end
      OP_NEG:  strobe.negSel = 1'b1;
      OP_MMAG: begin strobe.negSel = 1'b1; strobe.minMag = 1'b1; end
      OP_AND:  strobe.andSel = 1'b1;
      OP_SHL:  begin strobe.shiftSel = 1'b1; strobe.shiftLeft = 1'b1; end
      OP_SHR:  strobe.shiftSel = 1'b1;
      OP_PADD: begin strobe.addSel = 1'b1; strobe.split = 1'b1; end
      OP_PSUB: begin
        strobe.addSel = 1'b1; strobe.split = 1'b1; strobe.subtract = 1'b1;
      end
      OP_PSHL: begin
        strobe.shiftSel = 1'b1; strobe.split = 1'b1; strobe.shiftLeft = 1'b1;
        strobe.laneHiEn = 1'b1; strobe.laneLoEn = 1'b1;
      end
      OP_PSHR: begin
        strobe.shiftSel = 1'b1; strobe.split = 1'b1;
        strobe.laneHiEn = 1'b1; strobe.laneLoEn = 1'b1;
      end
      OP_HISR: begin
        strobe.shiftSel = 1'b1; strobe.split = 1'b1; strobe.laneHiEn = 1'b1;
      end
      OP_LOSR: begin
        strobe.shiftSel = 1'b1; strobe.split = 1'b1; strobe.laneLoEn = 1'b1;
      end
      OP_HISL: begin
        strobe.shiftSel = 1'b1; strobe.split = 1'b1; strobe.shiftLeft = 1'b1;
        strobe.laneHiEn = 1'b1;
      end
      OP_LOSL: begin
        strobe.shiftSel = 1'b1; strobe.split = 1'b1; strobe.shiftLeft = 1'b1;
        strobe.laneLoEn = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordTimes <= '0;
      resValid  <= 1'b0;
    end else begin
      resValid <= opGo;
      if (opGo) begin
        wordTimes <= strobe.shiftSel ? ({1'b0, shiftCnt} + LAT_W'(1)) : '0;
      end
    end
  end

endmodule

// File: rtl/split_word_dp.sv
module split_word_dp
  import split_word_pkg::*;
#(
  parameter int LANE_W = 11,
  parameter int MID_W  = 2,
  parameter int CNT_W  = 5,
  localparam int WORD_W = 2*LANE_W + MID_W,
  localparam int NLANES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [CNT_W-1:0]  shiftCnt,
  input  logic [WORD_W-1:0] aIn,
  input  logic [WORD_W-1:0] lIn,
  input  logic [WORD_W-1:0] nIn,
  output logic [WORD_W-1:0] aOut,
  output logic [WORD_W-1:0] lOut
);

  localparam logic [CNT_W:0] WORD_LIM = (CNT_W+1)'(WORD_W);

  logic [WORD_W-1:0] splitSum;
  logic [WORD_W-1:0] splitShift;
  logic [WORD_W-1:0] fullSum;
  logic [WORD_W-1:0] fullShift;
  logic [WORD_W-1:0] negA;
  logic [WORD_W-1:0] nextA;
  logic [NLANES-1:0] laneEn;
  logic              fullSat;

  // index 0 = low lane, index 1 = high lane
  assign laneEn = {strobe.laneHiEn, strobe.laneLoEn};

  assign splitSum[LANE_W +: MID_W]   = aIn[LANE_W +: MID_W];
  assign splitShift[LANE_W +: MID_W] = aIn[LANE_W +: MID_W];

  for (genvar g = 0; g < NLANES; g++) begin : g_lane
    localparam int BASE = g * (LANE_W + MID_W);
    logic [LANE_W-1:0] sumL;
    logic [LANE_W-1:0] shL;

    split_lane_unit #(.LANE_W(LANE_W), .CNT_W(CNT_W)) u_lane (
      .aLane     (aIn[BASE +: LANE_W]),
      .nLane     (nIn[BASE +: LANE_W]),
      .subtract  (strobe.subtract),
      .shiftLeft (strobe.shiftLeft),
      .shiftCnt  (shiftCnt),
      .sumLane   (sumL),
      .shiftLane (shL)
    );

    assign splitSum[BASE +: LANE_W]   = sumL;
    assign splitShift[BASE +: LANE_W] = laneEn[g] ? shL : aIn[BASE +: LANE_W];
  end

  assign fullSum = aIn + (strobe.subtract ? (~nIn + WORD_W'(1)) : nIn);
  assign negA    = ~aIn + WORD_W'(1);
  assign fullSat = ({1'b0, shiftCnt} >= WORD_LIM);

  always_comb begin
    if (strobe.shiftLeft) begin
      fullShift = fullSat ? '0 : (aIn << shiftCnt);
    end else begin
      fullShift = fullSat ? {WORD_W{aIn[WORD_W-1]}}
                          : WORD_W'($signed(aIn) >>> shiftCnt);
    end
  end

  always_comb begin
    nextA = aIn;
    if (strobe.addSel) begin
      nextA = strobe.split ? splitSum : fullSum;
    end else if (strobe.negSel) begin
      nextA = (strobe.minMag && aIn[WORD_W-1]) ? aIn : negA;
    end else if (strobe.andSel) begin
      nextA = aIn & lIn;
    end else if (strobe.shiftSel) begin
      nextA = strobe.split ? splitShift : fullShift;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      aOut <= '0;
      lOut <= '0;
    end else if (strobe.load) begin
      aOut <= nextA;
      lOut <= lIn;
    end
  end

endmodule

// File: rtl/split_word_alu.sv
module split_word_alu
  import split_word_pkg::*;
#(
  parameter int LANE_W = 11,
  parameter int MID_W  = 2,
  parameter int CNT_W  = 5,
  localparam int WORD_W = 2*LANE_W + MID_W,
  localparam int LAT_W  = CNT_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opGo,
  input  logic [3:0]        opCode,
  input  logic [CNT_W-1:0]  shiftCnt,
  input  logic [WORD_W-1:0] aIn,
  input  logic [WORD_W-1:0] lIn,
  input  logic [WORD_W-1:0] nIn,
  output logic [WORD_W-1:0] aOut,
  output logic [WORD_W-1:0] lOut,
  output logic [LAT_W-1:0]  wordTimes,
  output logic              resValid
);

  ctrlStrobe_t strobe;

  split_word_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .opGo      (opGo),
    .opCode    (opCode),
    .shiftCnt  (shiftCnt),
    .strobe    (strobe),
    .wordTimes (wordTimes),
    .resValid  (resValid)
  );

  split_word_dp #(.LANE_W(LANE_W), .MID_W(MID_W), .CNT_W(CNT_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .shiftCnt (shiftCnt),
    .aIn      (aIn),
    .lIn      (lIn),
    .nIn      (nIn),
    .aOut     (aOut),
    .lOut     (lOut)
  );

endmodule

// File: rtl/split_word_alu_chk.sv
module split_word_alu_chk #(
  parameter int LANE_W = 11,
  parameter int MID_W  = 2,
  parameter int CNT_W  = 5,
  localparam int WORD_W = 2*LANE_W + MID_W,
  localparam int LAT_W  = CNT_W + 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              opGo,
  input logic [3:0]        opCode,
  input logic [CNT_W-1:0]  shiftCnt,
  input logic [WORD_W-1:0] aIn,
  input logic [WORD_W-1:0] lIn,
  input logic [WORD_W-1:0] aOut,
  input logic [WORD_W-1:0] lOut,
  input logic [LAT_W-1:0]  wordTimes,
  input logic              resValid
);

  localparam int HI_LO = LANE_W + MID_W;

  logic isShift;
  logic isPacked;
  logic keepsHi;
  logic keepsLo;

  assign isShift  = (opCode == 4'd5) || (opCode == 4'd6) ||
                    ((opCode >= 4'd9) && (opCode <= 4'd14));
  assign isPacked = (opCode >= 4'd7) && (opCode <= 4'd14);
  assign keepsHi  = (opCode == 4'd12) || (opCode == 4'd14);
  assign keepsLo  = (opCode == 4'd11) || (opCode == 4'd13);

  AST_RESULT_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    opGo |=> resValid); // R2

  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rstN)
    !opGo |=> !resValid); // R2

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !opGo |=> ($stable(aOut) && $stable(lOut) && $stable(wordTimes))); // R2

  AST_L_CARRIED: assert property (@(posedge clk) disable iff (!rstN)
    opGo |=> (lOut == $past(lIn))); // R2

  AST_MID_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    (opGo && isPacked) |=> (aOut[LANE_W +: MID_W] == $past(aIn[LANE_W +: MID_W]))); // R7

  AST_HI_UNTOUCHED: assert property (@(posedge clk) disable iff (!rstN)
    (opGo && keepsHi) |=> (aOut[HI_LO +: LANE_W] == $past(aIn[HI_LO +: LANE_W]))); // R9

  AST_LO_UNTOUCHED: assert property (@(posedge clk) disable iff (!rstN)
    (opGo && keepsLo) |=> (aOut[LANE_W-1:0] == $past(aIn[LANE_W-1:0]))); // R9

  AST_LAT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (opGo && !isShift) |=> (wordTimes == '0)); // R10

  AST_LAT_SHIFT: assert property (@(posedge clk) disable iff (!rstN)
    (opGo && isShift) |=> (wordTimes == ({1'b0, $past(shiftCnt)} + LAT_W'(1)))); // R10

endmodule

bind split_word_alu split_word_alu_chk #(
  .LANE_W(LANE_W), .MID_W(MID_W), .CNT_W(CNT_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .opGo      (opGo),
  .opCode    (opCode),
  .shiftCnt  (shiftCnt),
  .aIn       (aIn),
  .lIn       (lIn),
  .aOut      (aOut),
  .lOut      (lOut),
  .wordTimes (wordTimes),
  .resValid  (resValid)
);

// File: tb/split_word_alu_bench.sv
module split_word_alu_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opGo = 1'b0;
  logic [3:0]  opCode = '0;
  logic [4:0]  shiftCnt = '0;
  logic [23:0] aIn = '0;
  logic [23:0] lIn = '0;
  logic [23:0] nIn = '0;
  logic [23:0] aOut;
  logic [23:0] lOut;
  logic [5:0]  wordTimes;
  logic        resValid;

  int  total = 0;
  int  bad = 0;
  bit  finished = 1'b0;
  logic [31:0] seed = 32'h1234_5678;

  always #(CLK_PERIOD/2) clk = ~clk;

  split_word_alu u_split_word_alu (
    .clk(clk), .rstN(rstN), .opGo(opGo), .opCode(opCode), .shiftCnt(shiftCnt),
    .aIn(aIn), .lIn(lIn), .nIn(nIn), .aOut(aOut), .lOut(lOut),
    .wordTimes(wordTimes), .resValid(resValid)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic longint pw(input int c);
    return longint'(1) << c;
  endfunction

  function automatic longint sval(input longint v, input int w);
    longint m = v & (pw(w) - 1);
    if (((m >> (w-1)) & 1) != 0) m = m - pw(w);
    return m;
  endfunction

  function automatic longint floorDiv(input longint v, input longint d);
    longint q = v / d;
    if (v < 0 && q * d != v) q = q - 1;
    return q;
  endfunction

  function automatic longint laneR(input longint v, input int c);
    return floorDiv(sval(v, 11), pw(c));
  endfunction

  function automatic longint pack3(input longint h, input longint m, input longint l);
    return ((h & 2047) << 13) | ((m & 3) << 11) | (l & 2047);
  endfunction

  function automatic logic [23:0] expA(input int op, input logic [23:0] a,
                                       input logic [23:0] l, input logic [23:0] n,
                                       input int c);
    longint av  = longint'(a);
    longint nv  = longint'(n);
    longint hi  = longint'(a[23:13]);
    longint mid = longint'(a[12:11]);
    longint lo  = longint'(a[10:0]);
    longint nh  = longint'(n[23:13]);
    longint nl  = longint'(n[10:0]);
    longint r;
    case (op)
      0:  r = av + nv;
      1:  r = av - nv;
      2:  r = -av;
      3:  r = (a[23] == 1'b0) ? -av : av;
      4:  r = longint'(a & l);
      5:  r = av * pw(c);
      6:  r = floorDiv(sval(av, 24), pw(c));
      7:  r = pack3(hi + nh, mid, lo + nl);
      8:  r = pack3(hi - nh, mid, lo - nl);
      9:  r = pack3(hi * pw(c), mid, lo * pw(c));
      10: r = pack3(laneR(hi, c), mid, laneR(lo, c));
      11: r = pack3(laneR(hi, c), mid, lo);
      12: r = pack3(hi, mid, laneR(lo, c));
      13: r = pack3(hi * pw(c), mid, lo);
      14: r = pack3(hi, mid, lo * pw(c));
      default: r = av;
    endcase
    return r[23:0];
  endfunction

  function automatic string reqOf(input int op);
    case (op)
      0, 1:      return "R3";
      2, 3, 15:  return "R4";
      4:         return "R5";
      5, 6:      return "R6";
      7, 8:      return "R7";
      9, 10:     return "R8";
      default:   return "R9";
    endcase
  endfunction

  function automatic bit isShiftOp(input int op);
    return (op == 5) || (op == 6) || (op >= 9 && op <= 14);
  endfunction

  task automatic runOp(input int op, input logic [23:0] a, input logic [23:0] l,
                       input logic [23:0] n, input int c);
    logic [23:0] e;
    @(negedge clk);
    opGo = 1'b1; opCode = 4'(op); aIn = a; lIn = l; nIn = n; shiftCnt = 5'(c);
    @(negedge clk);
    opGo = 1'b0;
    e = expA(op, a, l, n, c);
    chk(reqOf(op), $sformatf("aOut op=%0d a=%h n=%h c=%0d", op, a, n, c),
        32'(aOut), 32'(e));
    chk("R2", "lOut carries lIn", 32'(lOut), 32'(l));
    chk("R2", "resValid after issue", 32'(resValid), 32'd1);
    chk("R10", $sformatf("wordTimes op=%0d c=%0d", op, c), 32'(wordTimes),
        isShiftOp(op) ? 32'(c + 1) : 32'd0);
  endtask

  function automatic logic [23:0] nextRand();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed[23:0];
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [23:0] shPat [6];
    logic [23:0] corner [8];
    logic [23:0] heldA;
    shPat[0] = 24'h000001; shPat[1] = 24'h800000; shPat[2] = 24'h7FFFFF;
    shPat[3] = 24'hC03FF5; shPat[4] = 24'h2BCD55; shPat[5] = 24'hFFFFFF;
    corner[0] = 24'h000000; corner[1] = 24'h000001; corner[2] = 24'h7FFFFF;
    corner[3] = 24'h800000; corner[4] = 24'hFFFFFF; corner[5] = 24'hFFE7FF;
    corner[6] = 24'h001800; corner[7] = 24'h3FF3FF;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1", "aOut in reset", 32'(aOut), 32'd0);
    chk("R1", "lOut in reset", 32'(lOut), 32'd0);
    chk("R1", "wordTimes in reset", 32'(wordTimes), 32'd0);
    chk("R1", "resValid in reset", 32'(resValid), 32'd0);
    rstN = 1'b1;

    // shift sweep: every shift code, every count
    for (int op = 5; op <= 14; op++) begin
      if (op == 7 || op == 8) continue;
      for (int p = 0; p < 6; p++) begin
        for (int c = 0; c < 32; c++) begin
          runOp(op, shPat[p], shPat[5-p], 24'h0, c);
        end
      end
    end

    // arithmetic codes on corner pairs
    foreach (corner[i]) begin
      foreach (corner[j]) begin
        runOp(0, corner[i], corner[j], corner[j], 0);
        runOp(1, corner[i], corner[j], corner[j], 0);
        runOp(7, corner[i], corner[j], corner[j], 0);
        runOp(8, corner[i], corner[j], corner[j], 0);
        runOp(4, corner[i], corner[j], corner[j], 0);
      end
      runOp(2, corner[i], 24'h0, 24'h0, 3);
      runOp(3, corner[i], 24'h0, 24'h0, 3);
      runOp(15, corner[i], 24'h0, 24'h0, 3);
    end

    // pseudo-random operands for every non-shift code
    for (int k = 0; k < 150; k++) begin
      logic [23:0] ra, rl, rn;
      ra = nextRand(); rl = nextRand(); rn = nextRand();
      foreach (corner[q]) begin
        if (q == 0) begin
          runOp(0, ra, rl, rn, k % 32);
          runOp(1, ra, rl, rn, k % 32);
          runOp(2, ra, rl, rn, k % 32);
          runOp(3, ra, rl, rn, k % 32);
          runOp(4, ra, rl, rn, k % 32);
          runOp(7, ra, rl, rn, k % 32);
          runOp(8, ra, rl, rn, k % 32);
          runOp(15, ra, rl, rn, k % 32);
        end
      end
    end

    // R2: outputs hold while idle, inputs ignored without opGo
    runOp(5, 24'h00ABCD, 24'h123456, 24'h0, 4);
    heldA = aOut;
    @(negedge clk);
    aIn = 24'hFFFFFF; lIn = 24'h000000; nIn = 24'h555555; opCode = 4'd2; shiftCnt = 5'd1;
    repeat (3) @(negedge clk);
    chk("R2", "aOut holds while idle", 32'(aOut), 32'(heldA));
    chk("R2", "lOut holds while idle", 32'(lOut), 32'h123456);
    chk("R2", "wordTimes holds while idle", 32'(wordTimes), 32'd5);
    chk("R2", "resValid low while idle", 32'(resValid), 32'd0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule